// File: doc/BRIEF.md
# Sector Erase Command Sequencer

This block drives a byte-wide parallel flash through a simple bus master port (address, write data, read data, write strobe, read strobe, ready) to erase a list of sectors. A host loads a sector count and a packed list of sector byte addresses and pulses `start`. The sequencer writes the unlock-and-erase command burst for the first sector. It confirms through status polling that the flash took the command. While the flash's erase window stays open, it appends the remaining sectors with single erase-confirm writes.

Each appended sector can be guarded by a window-flag read before and after its write. A sector is reported as dropped if the window closed before the write, or had closed when it was read back after the write. A configuration input skips these guard reads when the host can guarantee short gaps between sector commands. The block then polls until the toggle bit stops toggling. It reports success, a rejected sector, a device fault or a watchdog timeout. On a fault or a timeout it first writes the reset command.

Top module: `sector_erase_seq`

## Requirements
- R1: After `start` with a count of 1 or more, the first six bus cycles are writes of (address/data) 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then first-sector address/0x30, in that order.
- R2: Two status reads at the first sector address follow. The command counts as accepted when status bit 6 differs between them or bit 7 of the second read is 0. If it is not accepted, the block ends with result 1 (rejected), an all-zero bitmap and no further bus cycles.
- R3: With `skip_win_chk` low, each further sector gets a status read at its address, a write of 0x30 to its address, and a second status read. If status bit 3 is 1 on the first read, the write is not issued. If bit 3 is 1 on the second read, the sector's bitmap bit stays 0. In both cases no further sector is added and the result is 1.
- R4: With `skip_win_chk` high, each further sector is a single write of 0x30 to its address, and its bitmap bit is set.
- R5: After the last sector, status reads at the first sector address repeat until two consecutive reads carry the same bit 6. The block then ends with result 0, or result 1 if a sector was dropped.
- R6: A completion read whose bit 6 still toggled but whose bit 5 is 1 is followed by a write of 0xF0 to address 0, and the result is 2 (fault).
- R7: A cycle counter runs from 0 while completion polling is in progress. A completion read that finds it at WDOG_LIMIT, with neither completion nor fault, is followed by the 0xF0 reset write, and the result is 3 (timeout).
- R8: The read and write strobes are never high together. A strobe, its address and its data hold steady until a cycle with `bus_rdy` high ends the transfer.
- R9: `done` is a one-cycle pulse ending each run, and `result` and `accepted` hold afterwards. A count of 0 ends with result 0 and no bus cycles. No strobe is raised while `busy` is low.
- R10: After reset, `busy`, `done`, both strobes, `result` and `accepted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| skip_win_chk | input | 1 | Skip the window-flag guard reads |
| sect_cnt | input | CNT_W | Number of sectors (clamped to MAX_SECT) |
| sect_list | input | MAX_SECT*ADDR_W | Packed sector byte addresses, entry 0 lowest |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 rejected, 2 fault, 3 timeout |
| accepted | output | MAX_SECT | Per-sector accepted bitmap |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data (status byte) |
| bus_rdy | input | 1 | Transfer ends in this cycle |

## Verification
The bench feeds the block from a behavioural flash whose toggle, window and fault bits follow the read count. It aims at a window that closes exactly between the pre-check and the post-check, which a design that trusted only the pre-check would wrongly report as accepted. A first command that never toggles must end the run at once. A design that went on would emit extra traffic. A fault must be caught ahead of the watchdog, and the timeout must land on exactly the read where the counter reaches its limit, which an off-by-one counter would miss by one read. Slow ready patterns test that strobes and addresses hold across stalls.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ACC, ST_PRE, ST_XWR, ST_POST, ST_WAIT, ST_RST, ST_DONE
  } fe_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_REJECT  = 2'd1,
    RES_FAULT   = 2'd2,
    RES_TIMEOUT = 2'd3
  } fe_result_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ERR  = 5;
  localparam int BIT_WIN  = 3;

  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  function automatic logic [11:0] unlock_addr(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: unlock_addr = 12'h2AA;
      default:    unlock_addr = 12'h555;
    endcase
  endfunction

  function automatic logic [7:0] unlock_data(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: unlock_data = 8'hAA;
      3'd1, 3'd4: unlock_data = 8'h55;
      3'd2:       unlock_data = 8'h80;
      default:    unlock_data = CMD_CONFIRM;
    endcase
  endfunction
endpackage

// File: rtl/fe_toggle_cmp.sv
module fe_toggle_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic bit_in,
  output logic seen,
  output logic same
);
  logic prev_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (clr) begin
      seen_q <= 1'b0;
    end else if (load) begin
      prev_q <= bit_in;
      seen_q <= 1'b1;
    end
  end

  assign seen = seen_q;
  assign same = seen_q && (bit_in == prev_q);
endmodule

// File: rtl/fe_wdog.sv
module fe_wdog #(
  parameter int LIMIT = 100000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)                   cnt_n = '0;
    else if (cnt_q != W'(LIMIT)) cnt_n = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
  import fe_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int MAX_SECT   = 8,
  parameter int WDOG_LIMIT = 100000,
  parameter int CNT_W      = $clog2(MAX_SECT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       skip_win_chk,
  input  logic [CNT_W-1:0]           sect_cnt,
  input  logic [MAX_SECT*ADDR_W-1:0] sect_list,
  output logic                       busy,
  output logic                       done,
  output logic [1:0]                 result,
  output logic [MAX_SECT-1:0]        accepted,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [7:0]                 bus_wdata,
  output logic                       bus_wr,
  output logic                       bus_rd,
  input  logic [7:0]                 bus_rdata,
  input  logic                       bus_rdy
);
  localparam int IDX_W = $clog2(MAX_SECT);

  logic [1:0]          rsync_q;
  logic                rst_sn;
  fe_state_e           state_q, state_n;
  logic [2:0]          cyc_q, cyc_n;
  logic [CNT_W-1:0]    idx_q, idx_n, cnt_q, cnt_n, cnt_in;
  logic [MAX_SECT-1:0] acc_q, acc_n;
  logic                rej_q, rej_n, byp_q, byp_n;
  fe_result_e          res_q, res_n;
  logic [ADDR_W-1:0]   sa_arr [MAX_SECT];
  logic [ADDR_W-1:0]   sa_first, sa_cur;
  logic                xfer, last, tg_seen, tg_same, tg_clr, tg_load, wd_exp;
  logic                unused_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  for (genvar g = 0; g < MAX_SECT; g++) begin : g_sa
    assign sa_arr[g] = sect_list[g*ADDR_W +: ADDR_W];
  end

  assign sa_first     = sa_arr[0];
  assign sa_cur       = sa_arr[idx_q[IDX_W-1:0]];
  assign cnt_in       = (sect_cnt > CNT_W'(MAX_SECT)) ? CNT_W'(MAX_SECT) : sect_cnt;
  assign last         = (idx_q + CNT_W'(1)) == cnt_q;
  assign unused_rdata = ^{bus_rdata[4], bus_rdata[2:0]};

  // bus decode from state
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      ST_CMD: begin
        bus_wr    = 1'b1;
        bus_addr  = (cyc_q == 3'd5) ? sa_first : ADDR_W'(unlock_addr(cyc_q));
        bus_wdata = unlock_data(cyc_q);
      end
      ST_ACC, ST_WAIT: begin
        bus_rd   = 1'b1;
        bus_addr = sa_first;
      end
      ST_PRE, ST_POST: begin
        bus_rd   = 1'b1;
        bus_addr = sa_cur;
      end
      ST_XWR: begin
        bus_wr    = 1'b1;
        bus_addr  = sa_cur;
        bus_wdata = CMD_CONFIRM;
      end
      ST_RST: begin
        bus_wr    = 1'b1;
        bus_wdata = CMD_RESET;
      end
      default: ;
    endcase
  end

  assign xfer = (bus_wr || bus_rd) && bus_rdy;

  // next-state logic
  always_comb begin
    state_n = state_q;
    cyc_n   = cyc_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    rej_n   = rej_q;
    res_n   = res_q;
    byp_n   = byp_q;
    case (state_q)
      ST_IDLE: if (start) begin
        cnt_n   = cnt_in;
        byp_n   = skip_win_chk;
        acc_n   = '0;
        rej_n   = 1'b0;
        idx_n   = '0;
        cyc_n   = '0;
        res_n   = RES_OK;
        state_n = (cnt_in == '0) ? ST_DONE : ST_CMD;
      end
      ST_CMD: if (xfer) begin
        if (cyc_q == 3'd5) state_n = ST_ACC;
        else               cyc_n = cyc_q + 3'd1;
      end
      ST_ACC: if (xfer && tg_seen) begin
        if (!tg_same || !bus_rdata[BIT_POLL]) begin
          acc_n[0] = 1'b1;
          idx_n    = CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_n = ST_WAIT;
          else                    state_n = byp_q ? ST_XWR : ST_PRE;
        end else begin
          rej_n   = 1'b1;
          res_n   = RES_REJECT;
          state_n = ST_DONE;
        end
      end
      ST_PRE: if (xfer) begin
        if (bus_rdata[BIT_WIN]) begin
          rej_n   = 1'b1;
          state_n = ST_WAIT;
        end else begin
          state_n = ST_XWR;
        end
      end
      ST_XWR: if (xfer) begin
        if (byp_q) begin
          acc_n[idx_q[IDX_W-1:0]] = 1'b1;
          idx_n   = idx_q + CNT_W'(1);
          state_n = last ? ST_WAIT : ST_XWR;
        end else begin
          state_n = ST_POST;
        end
      end
      ST_POST: if (xfer) begin
        if (bus_rdata[BIT_WIN]) begin
          rej_n   = 1'b1;
          state_n = ST_WAIT;
        end else begin
          acc_n[idx_q[IDX_W-1:0]] = 1'b1;
          idx_n   = idx_q + CNT_W'(1);
          state_n = last ? ST_WAIT : ST_PRE;
        end
      end
      ST_WAIT: if (xfer) begin
        if (tg_same) begin
          res_n   = rej_q ? RES_REJECT : RES_OK;
          state_n = ST_DONE;
        end else if (bus_rdata[BIT_ERR]) begin
          res_n   = RES_FAULT;
          state_n = ST_RST;
        end else if (wd_exp) begin
          res_n   = RES_TIMEOUT;
          state_n = ST_RST;
        end
      end
      ST_RST:  if (xfer) state_n = ST_DONE;
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign tg_clr  = (state_n != state_q);
  assign tg_load = xfer && bus_rd;

  fe_toggle_cmp u_tog (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr    (tg_clr),
    .load   (tg_load),
    .bit_in (bus_rdata[BIT_TOG]),
    .seen   (tg_seen),
    .same   (tg_same)
  );

  fe_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_sn),
    .run     (state_q == ST_WAIT),
    .expired (wd_exp)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      rej_q   <= 1'b0;
      res_q   <= RES_OK;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cyc_q   <= cyc_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      acc_q   <= acc_n;
      rej_q   <= rej_n;
      res_q   <= res_n;
      byp_q   <= byp_n;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign result   = res_q;
  assign accepted = acc_q;
endmodule

// File: rtl/sector_erase_seq_chk.sv
module sector_erase_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_rdy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata
);
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  a_r8_hold_until_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_rdy) |=>
      ($stable(bus_wr) && $stable(bus_rd) && $stable(bus_addr) && $stable(bus_wdata)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_wr || bus_rd));

  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r6_reset_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'hF0) |-> (bus_addr == '0));
endmodule

bind sector_erase_seq sector_erase_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sector_erase_seq.sv
module sim_sector_erase_seq;
  localparam int CLK_P    = 10;
  localparam int AW       = 17;
  localparam int NS       = 8;
  localparam int TB_LIMIT = 40;
  localparam int CW       = $clog2(NS + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            skip_win_chk = 1'b0;
  logic [CW-1:0]   sect_cnt = '0;
  logic [NS*AW-1:0] sect_list;
  logic            busy, done, bus_wr, bus_rd;
  logic [1:0]      result;
  logic [NS-1:0]   accepted;
  logic [AW-1:0]   bus_addr;
  logic [7:0]      bus_wdata;
  logic [7:0]      bus_rdata = '0;
  logic            bus_rdy = 1'b0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, per = 1, rd_idx = 0;
  int s_elen = 0, s_dq3 = 1000000, s_dq5 = 1000000;
  string cur_req = "R10";
  bit   done_seen = 0;
  bit   hold_v = 0;
  logic [AW+8:0] hold_s;
  logic [AW+8:0] exp_q [$];
  logic [1:0]    exp_res;
  logic [NS-1:0] exp_acc;

  sector_erase_seq #(.ADDR_W(AW), .MAX_SECT(NS), .WDOG_LIMIT(TB_LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_win_chk(skip_win_chk),
    .sect_cnt(sect_cnt), .sect_list(sect_list), .busy(busy), .done(done),
    .result(result), .accepted(accepted), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [AW-1:0] sa(input int i);
    return AW'(((i * 3 + 1) % 8) * 16384);
  endfunction

  // flash status byte as a function of how many reads have completed
  function automatic logic [7:0] fstat(input int r);
    logic [7:0] s;
    bit b;
    b = (r < s_elen);
    s = '0;
    s[7] = !b;
    s[6] = b ? ((r % 2) == 1) : 1'b1;
    s[5] = (r >= s_dq5);
    s[3] = (r >= s_dq3);
    return s;
  endfunction

  function automatic void check(input bit ok, input string req, input string what,
                                input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endfunction

  function automatic void pw(input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({1'b1, a, d});
  endfunction
  function automatic void pr(input logic [AW-1:0] a);
    exp_q.push_back({1'b0, a, 8'h00});
  endfunction

  // reference sequence built from the requirements
  task automatic build(input int cnt, input bit byp);
    int r;
    bit rej, pv;
    logic [7:0] s, s0, s1;
    exp_q.delete();
    exp_acc = '0;
    exp_res = 2'd0;
    rej = 0;
    pv = 0;
    if (cnt == 0) return;
    pw(17'h555, 8'hAA); pw(17'h2AA, 8'h55); pw(17'h555, 8'h80);
    pw(17'h555, 8'hAA); pw(17'h2AA, 8'h55); pw(sa(0), 8'h30);
    pr(sa(0)); pr(sa(0));
    s0 = fstat(0); s1 = fstat(1); r = 2;
    if (!((s0[6] != s1[6]) || !s1[7])) begin
      exp_res = 2'd1;
      return;
    end
    exp_acc[0] = 1'b1;
    for (int i = 1; i < cnt; i++) begin
      if (!byp) begin
        pr(sa(i)); s = fstat(r); r++;
        if (s[3]) begin rej = 1; break; end
      end
      pw(sa(i), 8'h30);
      if (!byp) begin
        pr(sa(i)); s = fstat(r); r++;
        if (s[3]) begin rej = 1; break; end
      end
      exp_acc[i] = 1'b1;
    end
    for (int j = 0; j < 100000; j++) begin
      pr(sa(0)); s = fstat(r); r++;
      if (j > 0 && s[6] == pv) begin exp_res = rej ? 2'd1 : 2'd0; break; end
      if (s[5]) begin pw('0, 8'hF0); exp_res = 2'd2; break; end
      if (j == TB_LIMIT) begin pw('0, 8'hF0); exp_res = 2'd3; break; end
      pv = s[6];
    end
  endtask

  // flash model and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      bus_rdy   = ((cyc % per) == 0);
      bus_rdata = fstat(rd_idx);
      if (rst_n) begin
        if (hold_v) begin
          check(hold_s == {bus_wr, bus_addr, bus_wdata}, "R8", "held cycle changed",
                32'(hold_s), 32'({bus_wr, bus_addr, bus_wdata}));
          hold_v = 0;
        end
        if (bus_wr || bus_rd) begin
          check(!(bus_wr && bus_rd), "R8", "both strobes", 32'({bus_wr, bus_rd}), 32'd0);
          if (!bus_rdy) begin
            hold_v = 1;
            hold_s = {bus_wr, bus_addr, bus_wdata};
          end else if (exp_q.size() == 0) begin
            check(1'b0, cur_req, "unexpected bus cycle", 32'({bus_wr, bus_addr}), 32'd0);
          end else begin
            logic [AW+8:0] e;
            e = exp_q.pop_front();
            if (e[AW+8])
              check({bus_wr, bus_addr, bus_wdata} == e, cur_req, "write",
                    32'({bus_wr, bus_addr, bus_wdata}), 32'(e));
            else
              check(bus_rd && bus_addr == e[AW+7:8], cur_req, "read",
                    32'({bus_rd, bus_addr}), 32'({1'b1, e[AW+7:8]}));
            if (bus_rd) rd_idx++;
          end
        end
        if (done) begin
          done_seen = 1;
          check(result == exp_res, cur_req, "result", 32'(result), 32'(exp_res));
          check(accepted == exp_acc, cur_req, "bitmap", 32'(accepted), 32'(exp_acc));
        end
      end
    end
  end

  task automatic run(input string req, input int cnt, input bit byp, input int elen,
                     input int dq3, input int dq5, input int p);
    bit got;
    @(negedge clk);
    cur_req = req;
    s_elen = elen; s_dq3 = dq3; s_dq5 = dq5; per = p;
    rd_idx = 0;
    done_seen = 0;
    build(cnt, byp);
    sect_cnt = CW'(cnt);
    skip_win_chk = byp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int k = 0; k < 5000 && !got; k++) begin
      @(negedge clk);
      got = done_seen;
    end
    check(got, req, "done seen", 32'(got), 32'd1);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, req, "cycles left unissued", 32'(exp_q.size()), 32'd0);
    check(!busy && !done, req, "idle after done", 32'({busy, done}), 32'd0);
    check(result == exp_res, "R9", "result held", 32'(result), 32'(exp_res));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) sect_list[i*AW +: AW] = sa(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !bus_wr && !bus_rd, "R10", "strobes/flags",
          32'({busy, done, bus_wr, bus_rd}), 32'd0);
    check(result == 2'd0 && accepted == '0, "R10", "result/bitmap",
          32'({result, accepted}), 32'd0);
    // R1 R2 R3 R5: three sectors, guarded, window stays open
    run("R5", 3, 0, 12, 1000000, 1000000, 1);
    // R4: bypass with a slow ready
    run("R4", 4, 1, 10, 1000000, 1000000, 3);
    // R3: window closed at the pre-check of sector 2
    run("R3", 4, 0, 20, 4, 1000000, 1);
    // R3: window closed between the pre-check and post-check of sector 1
    run("R3", 4, 0, 20, 3, 1000000, 2);
    // R2: first command never toggles
    run("R2", 3, 0, 0, 1000000, 1000000, 1);
    // R6: fault bit during completion polling
    run("R6", 2, 0, 1000, 1000000, 8, 1);
    // R7: no completion, watchdog
    run("R7", 1, 0, 1000, 1000000, 1000000, 1);
    // R9: count of zero
    run("R9", 0, 0, 12, 1000000, 1000000, 1);
    // R1 R5: single sector, slow ready
    run("R1", 1, 0, 9, 1000000, 1000000, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule